// File: doc/BRIEF.md
# Headphone Output Ramp Sequencer

This block sequences the power transitions of a stereo headphone output stage. Software owns a small byte-wide register space. Bit 6 of the power-control register puts the output stage in standby (1 = powered down). When a write flips that bit, the block runs a gain ramp: a position counter steps one unit per tick-enable pulse, towards `ramp_len` for power-up or towards zero for power-down. When the ramp reaches its end, the block sets a sticky done flag in the status register, either ramp-up-done at bit 3 or ramp-down-done at bit 2.

The expected driver sequence for power-up is: clear ramp-up-done, release standby, then poll until the flag reads 1. Power-down mirrors this with ramp-down-done and asserting standby. The status register is live hardware state, so reads always return its current value. A one-cycle interrupt pulse marks every rise of either flag.

The block has no streaming data path. All pins are plain control and status, and reads are combinational from `rd_addr`.

Top module: `hp_ramp_seq`

## Requirements
- R1: After reset the power-control register (address 2) reads 8'hFF, so the stage is in standby. Both done flags are 0, `gain_pos` is 0, and `ramping` and `irq` are 0.
- R2: A write to address 2 stores the byte, and it reads back. If bit 6 goes from 1 to 0, an up ramp starts. If bit 6 goes from 0 to 1, a down ramp starts. A write that leaves bit 6 unchanged starts no ramp. `ramping` is 1 from the edge after the starting write until the ramp ends.
- R3: During a ramp, `gain_pos` moves by exactly one towards its target on each clock edge where `tick` is 1. The target is `ramp_len` going up and 0 going down. `gain_pos` does not move on edges where `tick` is 0, nor on the edge of the starting write.
- R4: An up ramp ends on the edge where `gain_pos` reaches `ramp_len`, and that edge sets ramp-up-done (status bit 3). If `gain_pos` already equals the target when the ramp starts, the ramp ends on the next edge.
- R5: A down ramp ends on the edge where `gain_pos` reaches 0, and that edge sets ramp-down-done (status bit 2). The same rule for an already-reached target applies.
- R6: A flip of bit 6 during a ramp abandons that ramp. The opposite ramp continues from the current `gain_pos`, and only the new direction's flag is set when it ends.
- R7: A write to the status register (address 3) clears each done flag whose written bit is 0, and leaves unchanged each flag whose written bit is 1. The other status bits read 0, and unmapped addresses read 0.
- R8: If a ramp ends on the same edge as a write that clears its flag, the flag is set.
- R9: `irq` is high for exactly one cycle, on the cycle after the edge where either done flag goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |
| tick | input | 1 | Ramp step enable |
| ramp_len | input | CW | Ramp length in ticks (up target) |
| gain_pos | output | CW | Current ramp position |
| ramping | output | 1 | A ramp is in progress |
| irq | output | 1 | One-cycle pulse on a done-flag rise |

## Verification
The hardest case to reach is a ramp that finishes on exactly the edge where software writes 0 to the flag being set. The bench holds `tick` low and feeds single ticks until the position is one step short of `ramp_len`. In one cycle it then raises `tick` and issues the clearing write, so both events land on the same edge. Mid-ramp reversal is reached the same way: ticks stop part-way, and standby is flipped at a known position.

// File: rtl/hp_ramp_pkg.sv
package hp_ramp_pkg;
  localparam int REG_W     = 8;
  localparam int STB_BIT   = 6;
  localparam int UP_BIT    = 3;
  localparam int DN_BIT    = 2;
  localparam logic [REG_W-1:0] PWR_RESET = 8'hFF;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/hp_ramp_ctr.sv
module hp_ramp_ctr
  import hp_ramp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  dir_e          start_dir,
  input  logic          tick,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] pos,
  output logic          active,
  output logic          fin_up,
  output logic          fin_dn
);
  dir_e          dir;
  logic [CW-1:0] tgt, nxt;
  logic          at_tgt, step, finish;

  always_comb begin
    tgt    = (dir == DIR_UP) ? len : '0;
    at_tgt = (pos == tgt);
    nxt    = (pos < tgt) ? pos + 1'b1 : pos - 1'b1;
    step   = active && tick && !at_tgt && !start;
    finish = active && !start && (at_tgt || (step && nxt == tgt));
    fin_up = finish && (dir == DIR_UP);
    fin_dn = finish && (dir == DIR_DOWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      active <= 1'b0;
      dir    <= DIR_DOWN;
    end else if (start) begin
      active <= 1'b1;
      dir    <= start_dir;
    end else begin
      if (step)   pos    <= nxt;
      if (finish) active <= 1'b0;
    end
  end

  // R3: no movement without a tick
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos));
  // R3: a step is exactly one unit
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && !start && pos != tgt) |=>
      (pos == $past(pos) + 1'b1 || pos == $past(pos) - 1'b1));
  // R2: a start makes the ramp active
  a_r2_start_active: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
  // R4: up ramp ends at the programmed length
  a_r4_up_at_len: assert property (@(posedge clk) disable iff (!rst_n)
    fin_up |=> (pos == $past(len) && !active));
  // R5: down ramp ends at zero
  a_r5_dn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fin_dn |=> (pos == '0 && !active));
endmodule

// File: rtl/hp_ramp_regs.sv
module hp_ramp_regs
  import hp_ramp_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PWR_ADDR  = 2,
  parameter int STAT_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              fin_up,
  input  logic              fin_dn,
  output logic              start,
  output dir_e              start_dir,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] PWR_A  = ADDR_W'(PWR_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [REG_W-1:0] pwr_q;
  logic             up_q, dn_q, up_n, dn_n;
  logic             pwr_wr, stat_wr;

  always_comb begin
    pwr_wr    = wr_en && (wr_addr == PWR_A);
    stat_wr   = wr_en && (wr_addr == STAT_A);
    start     = pwr_wr && (wr_data[STB_BIT] != pwr_q[STB_BIT]);
    start_dir = wr_data[STB_BIT] ? DIR_DOWN : DIR_UP;
    up_n = fin_up ? 1'b1 : ((stat_wr && !wr_data[UP_BIT]) ? 1'b0 : up_q);
    dn_n = fin_dn ? 1'b1 : ((stat_wr && !wr_data[DN_BIT]) ? 1'b0 : dn_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_RESET;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (pwr_wr) pwr_q <= wr_data;
      up_q <= up_n;
      dn_q <= dn_n;
      irq  <= (up_n && !up_q) || (dn_n && !dn_q);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == PWR_A) rd_data = pwr_q;
    else if (rd_addr == STAT_A) begin
      rd_data[UP_BIT] = up_q;
      rd_data[DN_BIT] = dn_q;
    end
  end

  // R7: writing 1 keeps a set flag
  a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[UP_BIT] && up_q && !fin_dn) |=> up_q);
  // R8: a finishing ramp always leaves its flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fin_up |=> up_q);
  // R9: irq only after a flag rise
  a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((up_q && !$past(up_q)) || (dn_q && !$past(dn_q))));
  // R9: pulse lasts one cycle unless another rise follows
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fin_up && !fin_dn) |=> !irq);
endmodule

// File: rtl/hp_ramp_seq.sv
module hp_ramp_seq
  import hp_ramp_pkg::*;
#(
  parameter int CW     = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tick,
  input  logic [CW-1:0]     ramp_len,
  output logic [CW-1:0]     gain_pos,
  output logic              ramping,
  output logic              irq
);
  logic start, fin_up, fin_dn;
  dir_e start_dir;

  hp_ramp_regs #(.ADDR_W(ADDR_W), .PWR_ADDR(2), .STAT_ADDR(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fin_up(fin_up), .fin_dn(fin_dn), .start(start),
    .start_dir(start_dir), .irq(irq)
  );

  hp_ramp_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .tick(tick), .len(ramp_len), .pos(gain_pos), .active(ramping),
    .fin_up(fin_up), .fin_dn(fin_dn)
  );

  // R6: a reversal never finishes the abandoned direction on its edge
  a_r6_no_stale_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !(fin_up || fin_dn));
endmodule

// File: tb/hp_ramp_seq_bench.sv
module hp_ramp_seq_bench;
  localparam int CW = 4;
  localparam logic [3:0] PWR = 4'd2, STAT = 4'd3;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = STAT;
  logic [7:0] wr_data = '0, rd_data;
  logic [CW-1:0] ramp_len = '0, gain_pos;
  logic ramping, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hp_ramp_seq #(.CW(CW), .ADDR_W(4)) u_hp_ramp_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick(tick), .ramp_len(ramp_len), .gain_pos(gain_pos),
    .ramping(ramping), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // waits for a status bit; n = edges taken, irqs = irq samples seen (incl. one after)
  task automatic wait_flag(input int bitpos, output int n, output int irqs);
    n = 0; irqs = 0;
    while (n < 64) begin
      @(negedge clk);
      n++;
      if (irq) irqs++;
      if (rd_data[bitpos]) break;
    end
    @(negedge clk);
    if (irq) irqs++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, irqs, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 flags", rd_data, 0);
    chk(gain_pos == 0 && !ramping && !irq, "R1 idle", gain_pos, 0);
    rd_addr = PWR; #1;
    chk(rd_data == 8'hFF, "R1 power reg", rd_data, 255);
    // R2 write keeping bit 6 starts nothing
    wr(PWR, 8'hC0);
    chk(rd_data == 8'hC0, "R2 readback", rd_data, 192);
    chk(!ramping, "R2 no start", ramping, 0);
    rd_addr = 4'hF; #1;
    chk(rd_data == 0, "R7 unmapped", rd_data, 0);
    rd_addr = STAT;

    // R4/R5/R9 sweep over every length with tick held high
    tick = 1'b1;
    for (int L = 0; L < 16; L++) begin
      ramp_len = CW'(L);
      exp = (L == 0) ? 1 : L;
      wr(STAT, 8'h00);
      wr(PWR, 8'h80);
      wait_flag(3, n, irqs);
      chk(n == exp, "R4 up edges", n, exp);
      chk(gain_pos == CW'(L) && !ramping, "R4 up end pos", gain_pos, L);
      chk(irqs == 1, "R9 up irq", irqs, 1);
      wr(STAT, 8'h08);
      chk(rd_data == 8'h08, "R7 write one keeps", rd_data, 8);
      wr(PWR, 8'hC0);
      wait_flag(2, n, irqs);
      chk(n == exp, "R5 down edges", n, exp);
      chk(gain_pos == 0 && !ramping, "R5 down end pos", gain_pos, 0);
      chk(irqs == 1, "R9 down irq", irqs, 1);
      chk((rd_data & 8'hF3) == 0, "R7 other bits", rd_data & 8'hF3, 0);
    end

    // R3 no movement without tick, single steps with it
    tick = 1'b0;
    ramp_len = 4'd8;
    wr(STAT, 8'h00);
    wr(PWR, 8'h80);
    repeat (10) @(negedge clk);
    chk(gain_pos == 0 && ramping, "R3 hold without tick", gain_pos, 0);
    for (int k = 1; k <= 3; k++) begin
      pulse_tick();
      chk(gain_pos == CW'(k), "R3 single step", gain_pos, k);
    end
    // R6 reversal from position 3
    wr(PWR, 8'hC0);
    chk(gain_pos == 3 && ramping, "R6 start keeps pos", gain_pos, 3);
    tick = 1'b1;
    wait_flag(2, n, irqs);
    chk(n == 3, "R6 down from current pos", n, 3);
    chk(rd_data == 8'h04, "R6 only new flag", rd_data, 4);

    // R8 clear write on the finishing edge
    tick = 1'b0;
    ramp_len = 4'd5;
    wr(STAT, 8'h00);
    chk(rd_data == 8'h00, "R7 write zero clears", rd_data, 0);
    wr(PWR, 8'h80);
    repeat (4) pulse_tick();
    chk(gain_pos == 4, "R8 setup pos", gain_pos, 4);
    tick = 1'b1;
    wr(STAT, 8'h00);
    tick = 1'b0;
    chk(rd_data[3] == 1'b1, "R8 set wins", rd_data[3], 1);
    chk(irq == 1'b1, "R9 irq on set-wins", irq, 1);
    wr(STAT, 8'h00);
    chk(rd_data == 8'h00 && !irq, "R7 clear after", rd_data, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule